// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked system and an external asynchronous static RAM of 512K words by 16 bits. The RAM has active-low chip select, write strobe, output enable and a pair of byte-lane enables. A single-word request comes in with an address, write data and a 2-bit lane mask. The block turns it into a strobe sequence whose phase lengths, in clock cycles, come from the RAM's nanosecond minimums. Those minimums and the clock period are parameters, and each phase is rounded up to whole cycles with a floor of one cycle.

Each access goes through five states. IDLE holds every strobe high and takes requests (IDLE->SETUP on an accepted request). SETUP presents the address with chip select and the selected lane enables low (SETUP->STROBE after the setup count). STROBE pulses the write strobe for a write, or the output enable for a read (STROBE->HOLD after the strobe count). HOLD raises every strobe; a write leaves it for IDLE (HOLD->IDLE), and a read leaves it for TURNAROUND (HOLD->TURNAROUND). TURNAROUND waits with the bus undriven while the RAM's outputs turn off (TURNAROUND->IDLE).

Read data is captured on the edge that ends STROBE and is flagged by a one-cycle valid pulse. Lanes that were not selected read back as zero.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, ready is 1, busy is 0, rd_valid is 0, the data-bus drive is off, and all five RAM strobes are high.
- R2: A request is taken only on a clock edge where ready is 1. A request raised while busy is ignored and leaves both the RAM contents and the access in progress unchanged.
- R3: A write spends 1 SETUP cycle with chip select low and write strobe high. It then spends max(1, ceil(T_WP/T_CLK)) STROBE cycles with chip select and write strobe low. It ends with 1 HOLD cycle in which all strobes are high. Output enable stays high throughout.
- R4: During a write, the data bus is driven with the request's data from SETUP through HOLD. The bus is never driven in any other cycle.
- R5: Mask bit 0 drives the lower lane enable, which covers data bits 7:0. Mask bit 1 drives the upper lane enable, which covers data bits 15:8. The enable is low in SETUP and STROBE only when its mask bit is 1. A write with mask 00 changes no RAM data.
- R6: A read spends 1 SETUP cycle with chip select low. It then spends max(1, ceil(T_RC/T_CLK)) STROBE cycles with chip select and output enable low. It ends with 1 HOLD cycle in which all strobes are high.
- R7: rd_valid is high for exactly one cycle, the cycle after the last read STROBE cycle. In that cycle rd_data holds the RAM word, with the bits of each unselected lane forced to zero.
- R8: After a read's HOLD, the block stays in TURNAROUND for max(1, ceil(T_TURN/T_CLK)) cycles with all strobes high and the bus undriven. While the RAM drives data, the block never drives the bus.
- R9: The RAM address changes only on an edge where every strobe was high in the cycle before.
- R10: busy equals the inverse of ready. busy rises on the edge after an accepted request and stays high until the access returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when ready is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| ready | output | 1 | High in IDLE |
| busy | output | 1 | High while an access is in progress |
| rd_data | output | 16 | Captured read data, unselected lanes zero |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| mem_addr | output | 19 | RAM address bus |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | RAM low-lane enable, active low |
| mem_ub_n | output | 1 | RAM high-lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enables the bus drive of mem_dq_out |
| mem_dq_in | input | 16 | Data read from the RAM bus |

## Verification
Writes and reads run with each of the four lane masks against one address, so that merged words show whether each lane was gated on its own. A mask-00 write followed by a readback separates "no write" from "write of zeros". Back-to-back read-then-write and write-then-read pairs test the turnaround gap and the bus ownership, which the RAM model watches for contention. A request raised mid-access, followed by a read of its address, shows whether a busy block wrongly accepts work.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN
    } seq_state_t;

    // Whole cycles covering a nanosecond minimum, never below one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] len,
    output logic         last
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == len - 1'b1);

endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [LANES-1:0]        sel,
    output logic [LANES*LANE_W-1:0] dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*LANE_W +: LANE_W] = sel[g] ? din[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int LANE_W        = 8,
    parameter int LANES         = 2,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_AS_NS       = 0,
    parameter int T_WP_NS       = 8,
    parameter int T_WR_NS       = 0,
    parameter int T_RC_NS       = 10,
    parameter int T_TURN_NS     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     req_we,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LANES*LANE_W-1:0]  req_wdata,
    input  logic [LANES-1:0]         req_be,
    output logic                     ready,
    output logic                     busy,
    output logic [LANES*LANE_W-1:0]  rd_data,
    output logic                     rd_valid,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_ce_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic                     mem_lb_n,
    output logic                     mem_ub_n,
    output logic [LANES*LANE_W-1:0]  mem_dq_out,
    output logic                     mem_dq_oe,
    input  logic [LANES*LANE_W-1:0]  mem_dq_in
);

    localparam int DATA_W    = LANES * LANE_W;
    localparam int SETUP_CYC = ns_to_cyc(T_AS_NS, CLK_PERIOD_NS);
    localparam int WP_CYC    = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC  = ns_to_cyc(T_WR_NS, CLK_PERIOD_NS);
    localparam int RC_CYC    = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int TURN_CYC  = ns_to_cyc(T_TURN_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC   = max2(max2(max2(SETUP_CYC, WP_CYC), max2(HOLD_CYC, RC_CYC)), TURN_CYC);
    localparam int CNT_W     = $clog2(MAX_CYC + 1) + 1;

    seq_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              we_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_masked;
    logic [CNT_W-1:0]  phase_len;
    logic              phase_last;
    logic              phase_clr;
    logic              accept;

    assign accept = req && (state_q == ST_IDLE);

    // Phase length for the current state.
    always_comb begin
        unique case (state_q)
            ST_SETUP:  phase_len = CNT_W'(SETUP_CYC);
            ST_STROBE: phase_len = we_q ? CNT_W'(WP_CYC) : CNT_W'(RC_CYC);
            ST_HOLD:   phase_len = CNT_W'(HOLD_CYC);
            ST_TURN:   phase_len = CNT_W'(TURN_CYC);
            default:   phase_len = CNT_W'(1);
        endcase
    end

    assign phase_clr = (state_d != state_q) || (state_q == ST_IDLE);

    sram_phase_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_clr),
        .len   (phase_len),
        .last  (phase_last)
    );

    sram_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_mask (
        .din  (mem_dq_in),
        .sel  (be_q),
        .dout (rd_masked)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req)        state_d = ST_SETUP;
            ST_SETUP:  if (phase_last) state_d = ST_STROBE;
            ST_STROBE: if (phase_last) state_d = ST_HOLD;
            ST_HOLD:   if (phase_last) state_d = we_q ? ST_IDLE : ST_TURN;
            ST_TURN:   if (phase_last) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture; the address only moves while every strobe is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            we_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            we_q    <= req_we;
        end
    end

    // Read capture on the edge that closes the read strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            if (state_q == ST_STROBE && !we_q && phase_last) begin
                rd_data_q  <= rd_masked;
                rd_valid_q <= 1'b1;
            end
        end
    end

    // Outputs decoded from state.
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_lb_n  = 1'b1;
        mem_ub_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TURN: ;
            ST_SETUP: begin
                mem_ce_n  = 1'b0;
                mem_lb_n  = ~be_q[0];
                mem_ub_n  = ~be_q[1];
                mem_dq_oe = we_q;
            end
            ST_STROBE: begin
                mem_ce_n  = 1'b0;
                mem_lb_n  = ~be_q[0];
                mem_ub_n  = ~be_q[1];
                mem_we_n  = ~we_q;
                mem_oe_n  = we_q;
                mem_dq_oe = we_q;
            end
            ST_HOLD: mem_dq_oe = we_q;
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign ready      = (state_q == ST_IDLE);
    assign busy       = (state_q != ST_IDLE);
    assign rd_data    = rd_data_q;
    assign rd_valid   = rd_valid_q;

    // Write strobe and output enable never low together.
    p_we_oe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // No bus drive while the RAM outputs are enabled.
    p_no_fight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    // A read's hold always leads into the turnaround gap.
    p_turn_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !we_q) |=> (state_q == ST_TURN));

    // Address moves only after a cycle with every strobe high.
    p_addr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> $past(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n));

    // Valid is a single-cycle pulse.
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // An accepted request makes the block busy on the next cycle.
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> busy);

    // A request while busy does not disturb the latched address.
    p_busy_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_seq_ctrl_tb.sv
module sram_seq_ctrl_tb;

    localparam int PER = 3;   // logical period fed to the timing parameters
    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int WP   = cyc(8);
    localparam int RC   = cyc(10);
    localparam int TURN = cyc(4);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ready, busy, rd_valid;
    logic [15:0] rd_data;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    int vectors = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sram_seq_ctrl #(.CLK_PERIOD_NS(PER)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ready(ready), .busy(busy),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic bad(input string tag, input string what, input longint act, input longint exp);
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    endtask

    // ---------------- behavioural RAM model ----------------
    logic [15:0] ram [int];
    function automatic logic [15:0] ram_rd(input int a);
        return ram.exists(a) ? ram[a] : 16'h0000;
    endfunction

    wire rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
    wire wr_on = !mem_ce_n && !mem_we_n && (!mem_lb_n || !mem_ub_n);
    assign mem_dq_in = rd_on ? {mem_ub_n ? 8'hA5 : ram_rd(int'(mem_addr))[15:8],
                                mem_lb_n ? 8'h5A : ram_rd(int'(mem_addr))[7:0]}
                             : 16'hDEAD;

    logic        was_wr = 0, was_low = 0, wr_lb = 0, wr_ub = 0;
    logic [18:0] prev_addr = '0, wr_addr = '0;
    logic [15:0] wr_data = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_on && mem_dq_oe) bad("R8", "bus contention", 1, 0);
            if (mem_addr != prev_addr && was_low) bad("R9", "address moved under strobe", mem_addr, prev_addr);
            if (wr_on) begin
                wr_addr = mem_addr; wr_data = mem_dq_out; wr_lb = !mem_lb_n; wr_ub = !mem_ub_n;
            end else if (was_wr) begin
                logic [15:0] w;
                w = ram_rd(int'(wr_addr));
                if (wr_lb) w[7:0]  = wr_data[7:0];
                if (wr_ub) w[15:8] = wr_data[15:8];
                ram[int'(wr_addr)] = w;
            end
        end
        was_wr    = wr_on;
        was_low   = !(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n);
        prev_addr = mem_addr;
    end

    // ---------------- cycle reference model ----------------
    logic [15:0] exp_mem [int];
    function automatic logic [15:0] exp_rd(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
    endfunction

    int          k = 0;
    bit          op_we = 0;
    logic [1:0]  op_be = 0;
    logic [18:0] op_addr = 0;
    logic [15:0] op_data = 0, op_rexp = 0;

    always @(negedge clk) begin
        if (!done) begin
            bit e_ce, e_we, e_oe, e_lb, e_ub, e_drv, e_val;
            int total;
            string t;
            total = op_we ? WP + 2 : RC + 2 + TURN;
            e_ce = 1; e_we = 1; e_oe = 1; e_lb = 1; e_ub = 1; e_drv = 0; e_val = 0;
            if (k >= 1 && k <= 1 + (op_we ? WP : RC)) begin
                e_ce = 0; e_lb = !op_be[0]; e_ub = !op_be[1];   // R5
                if (k >= 2) begin
                    if (op_we) e_we = 0; else e_oe = 0;
                end
            end
            if (op_we && k >= 1 && k <= WP + 2) e_drv = 1;       // R4
            if (!op_we && k == RC + 2) e_val = 1;               // R7
            t = (k == 0) ? "R1" : (op_we ? "R3" : "R6");
            vectors++;
            if (ready !== (k == 0))    bad((k == 0) ? "R1" : "R10", "ready", ready, k == 0);
            if (busy !== (k != 0))     bad("R10", "busy", busy, k != 0);
            if (mem_ce_n !== e_ce)     bad(t, "ce_n", mem_ce_n, e_ce);
            if (mem_we_n !== e_we)     bad("R3", "we_n", mem_we_n, e_we);
            if (mem_oe_n !== e_oe)     bad("R6", "oe_n", mem_oe_n, e_oe);
            if (mem_lb_n !== e_lb)     bad("R5", "lb_n", mem_lb_n, e_lb);
            if (mem_ub_n !== e_ub)     bad("R5", "ub_n", mem_ub_n, e_ub);
            if (mem_dq_oe !== e_drv)   bad((k > RC + 2) ? "R8" : "R4", "dq_oe", mem_dq_oe, e_drv);
            if (rd_valid !== e_val)    bad("R7", "rd_valid", rd_valid, e_val);
            if (k != 0 && mem_addr !== op_addr) bad("R2", "mem_addr", mem_addr, op_addr);
            if (e_drv && mem_dq_out !== op_data) bad("R4", "dq_out", mem_dq_out, op_data);
            if (e_val && rd_data !== op_rexp)    bad("R7", "rd_data", rd_data, op_rexp);
            if (rst_n) begin
                if (k == 0 && req) begin
                    k = 1; op_we = req_we; op_be = req_be; op_addr = req_addr; op_data = req_wdata;
                    if (req_we) begin
                        logic [15:0] w;
                        w = exp_rd(int'(req_addr));
                        if (req_be[0]) w[7:0]  = req_wdata[7:0];
                        if (req_be[1]) w[15:8] = req_wdata[15:8];
                        exp_mem[int'(req_addr)] = w;
                    end else begin
                        op_rexp = exp_rd(int'(req_addr)) & {{8{req_be[1]}}, {8{req_be[0]}}};
                    end
                end else if (k != 0) begin
                    k = (k == total) ? 0 : k + 1;
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit we, input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
        @(posedge clk); #2;
        while (!ready) begin @(posedge clk); #2; end
        req = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk); #2;
        req = 0;
    endtask

    task automatic settle();
        repeat (12) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R5 lane merging at one address
        issue(1, 19'h00A1, 16'h1234, 2'b11);
        issue(0, 19'h00A1, 16'h0000, 2'b11);
        issue(1, 19'h00A1, 16'hFFFF, 2'b01);
        issue(0, 19'h00A1, 16'h0000, 2'b11);
        issue(1, 19'h00A1, 16'hAB00, 2'b10);
        issue(0, 19'h00A1, 16'h0000, 2'b01);
        issue(0, 19'h00A1, 16'h0000, 2'b10);
        issue(0, 19'h00A1, 16'h0000, 2'b00);
        // R5 mask 00 write must not change data
        issue(1, 19'h00A1, 16'h0000, 2'b00);
        issue(0, 19'h00A1, 16'h0000, 2'b11);
        // R2 request raised mid-access is ignored
        issue(1, 19'h7FFFF, 16'hC3C3, 2'b11);
        #1 req = 1; req_we = 1; req_addr = 19'h00B2; req_wdata = 16'h9999; req_be = 2'b11;
        @(posedge clk); #2 req = 0;
        issue(0, 19'h00B2, 16'h0000, 2'b11);
        issue(0, 19'h7FFFF, 16'h0000, 2'b11);
        // R8 read directly followed by write, and the reverse
        issue(0, 19'h00A1, 16'h0000, 2'b11);
        issue(1, 19'h0003, 16'h5AA5, 2'b11);
        issue(0, 19'h0003, 16'h0000, 2'b11);
        // pseudo-random mix
        begin
            logic [31:0] lf;
            lf = 32'h1ACE_B00C;
            for (int i = 0; i < 60; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                issue(lf[7], {16'h0, lf[2:0]}, lf[31:16], lf[9:8]);
            end
        end
        settle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R10 actual=busy expected=idle");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule